// File: doc/BRIEF.md
# RF Drive Interlock with Vacuum Hysteresis

This block sits between the RF drive generator and the DAC that feeds the amplifier chain. It cuts the drive to zero whenever the RF load looks unsafe. It has two separate ways to trip.

The fast path compares the reflected amplitude of every accepted RF pulse against a trip level. It cuts the drive within the same clock cycle and holds the drive off until software clears it. The slow path keeps its own saturating count of breakdowns, where a breakdown is a pulse whose reflected amplitude exceeds a lower breakdown level. It also tracks a vacuum-degraded flag, which has separate levels for setting and for clearing. When the count is above its limit while the vacuum is degraded, the drive is killed at once. It stays off until the vacuum flag has cleared.

Every breakdown also raises a capture request, which carries the offending amplitude, so an external recorder can store the reflected waveform. A 2-bit status output reports which condition caused the most recent trip.

Reflected amplitudes arrive on a valid/ready stream. The block keeps `in_ready` high except while a capture request is pending and the recorder holds `cap_ready` low. This keeps a breakdown from being lost while the previous capture is waiting. The capture output is also valid/ready: once raised, `cap_valid` and `cap_amp` hold steady until `cap_ready` is seen high at a clock edge. Pressure, thresholds, clear and DAC data are plain level inputs.

Top module: `rf_interlock`

## Requirements
- R1: When a pulse with amplitude strictly above `trip_thr` is accepted (`in_valid && in_ready`), `kill` goes to 1 and `dac_out` goes to 0 in that same cycle, and the trip is latched at the clock edge.
- R2: A latched reflected-power trip clears only at an edge where `clr` is 1, no pulse above `trip_thr` is being accepted, and the count-and-vacuum condition is false; until then `kill` stays 1 whatever pulses arrive.
- R3: `vac_degraded` sets when `pressure > ` trip level and clears only when `pressure < ` recovery level (strictly below); for pressures in between, and at exactly the recovery level, it holds its value. It is updated every clock.
- R4: Whenever `bd_count > cnt_limit` and `vac_degraded` is 1, `kill` is 1 in the same cycle. This trip latches, ignores `clr`, and releases at the second edge after `vac_degraded` returns to 0.
- R5: Pressure is an unsigned linear word in units of 1e-7 Pa. After reset, the trip level is 100 (1e-5 Pa) and the recovery level is 50 (5e-6 Pa). A cycle with `cfg_we` high loads both levels from `cfg_trip` and `cfg_rec`.
- R6: Each accepted pulse with amplitude strictly above `bd_thr` increments `bd_count`, which saturates at all ones. `bd_count` is zeroed at an edge meeting the R2 clear conditions.
- R7: Each breakdown raises `cap_valid` at the next edge, with `cap_amp` equal to that pulse's amplitude. It is transferred exactly once, and it stays stable while `cap_ready` is 0.
- R8: `in_ready` is 0 exactly while `cap_valid` is 1 and `cap_ready` is 0.
- R9: `trip_cause` is 0 after reset. It becomes 1 when a reflected-power trip latches and 2 when a count-and-vacuum trip latches, with 1 winning a tie, and it otherwise holds.
- R10: After reset, `kill` is 0, `dac_out` equals `dac_in`, `bd_count` is 0, `cap_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Reflected amplitude sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_amp | input | AMP_W | Peak reflected amplitude of one pulse |
| bd_thr | input | AMP_W | Breakdown detection level |
| trip_thr | input | AMP_W | Fast reflected-power trip level |
| cnt_limit | input | CNT_W | Breakdown count limit for the vacuum trip |
| bd_count | output | CNT_W | Saturating breakdown count |
| pressure | input | PRES_W | Digitised vacuum pressure |
| cfg_we | input | 1 | Load new vacuum levels |
| cfg_trip | input | PRES_W | New vacuum trip level |
| cfg_rec | input | PRES_W | New vacuum recovery level |
| vac_degraded | output | 1 | Vacuum hysteresis flag |
| clr | input | 1 | Software clear request |
| dac_in | input | DAC_W | Drive word from the generator |
| dac_out | output | DAC_W | Drive word to the DAC, zero when killed |
| kill | output | 1 | Drive cut active |
| trip_cause | output | 2 | Most recent trip cause: 0 none, 1 reflected, 2 vacuum |
| cap_valid | output | 1 | Waveform capture request pending |
| cap_ready | input | 1 | Recorder accepts the capture request |
| cap_amp | output | AMP_W | Amplitude of the breakdown that triggered capture |

## Verification
The bench walks the pressure through the hysteresis band, including exactly the recovery level and one code below it. A design that compared with the wrong bound would drop the degraded flag too early, and would release the vacuum trip while the pressure is still high. It asserts `clr` during a vacuum trip and again while an over-threshold pulse is arriving. A design that honoured the clear there would restore drive into a fault. Holding `cap_ready` low checks that a design without proper back-pressure would either drop the pending capture or accept a new pulse over it. Driving more breakdowns than the count can hold shows whether the counter wraps to a small value instead of saturating.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_REFL = 2'd1,
    CAUSE_VAC  = 2'd2
  } cause_e;
endpackage

// File: rtl/rfi_vac_monitor.sv
module rfi_vac_monitor #(
  parameter int PRES_W   = 16,
  parameter int DEF_TRIP = 100,
  parameter int DEF_REC  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PRES_W-1:0] cfg_trip,
  input  logic [PRES_W-1:0] cfg_rec,
  input  logic [PRES_W-1:0] pressure,
  output logic              degraded
);
  localparam logic [PRES_W-1:0] TRIP_RST = PRES_W'(DEF_TRIP);
  localparam logic [PRES_W-1:0] REC_RST  = PRES_W'(DEF_REC);

  logic [PRES_W-1:0] trip_lvl;
  logic [PRES_W-1:0] rec_lvl;
  logic              above_trip;
  logic              below_rec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_lvl <= TRIP_RST;
      rec_lvl  <= REC_RST;
    end else if (cfg_we) begin
      trip_lvl <= cfg_trip;
      rec_lvl  <= cfg_rec;
    end
  end

  assign above_trip = pressure > trip_lvl;
  assign below_rec  = pressure < rec_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          degraded <= 1'b0;
    else if (above_trip) degraded <= 1'b1;
    else if (below_rec)  degraded <= 1'b0;
  end

  AST_DEGRADE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(degraded) |-> $past(pressure > trip_lvl)); // R3
  AST_DEGRADE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(degraded) |-> $past(pressure < rec_lvl)); // R3
endmodule

// File: rtl/rfi_bd_tracker.sv
module rfi_bd_tracker #(
  parameter int AMP_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [AMP_W-1:0] in_amp,
  input  logic [AMP_W-1:0] bd_thr,
  input  logic             cnt_clear,
  input  logic             cap_ready,
  output logic             in_ready,
  output logic             accept,
  output logic [CNT_W-1:0] count,
  output logic             cap_valid,
  output logic [AMP_W-1:0] cap_amp
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic bd_hit;

  assign in_ready = !cap_valid || cap_ready;
  assign accept   = in_valid && in_ready;
  assign bd_hit   = accept && (in_amp > bd_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (cnt_clear)                  count <= '0;
    else if (bd_hit && count != CNT_MAX) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_amp   <= '0;
    end else if (bd_hit) begin
      cap_valid <= 1'b1;
      cap_amp   <= in_amp;
    end else if (cap_ready) begin
      cap_valid <= 1'b0;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> (cap_valid && $stable(cap_amp))); // R7
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == CNT_MAX) && !cnt_clear) |=> (count == CNT_MAX)); // R6
endmodule

// File: rtl/rfi_trip_ctrl.sv
module rfi_trip_ctrl
  import rfi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_hit,
  input  logic       vac_cond,
  input  logic       vac_degraded,
  input  logic       clr,
  output logic       clr_ok,
  output logic       kill,
  output logic [1:0] cause
);
  logic   fast_lat;
  logic   vac_lat;
  cause_e cause_q;

  assign clr_ok = clr && !fast_hit && !vac_cond;
  assign kill   = fast_lat || vac_lat || fast_hit || vac_cond;
  assign cause  = cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fast_lat <= 1'b0;
    else if (fast_hit) fast_lat <= 1'b1;
    else if (clr_ok)   fast_lat <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vac_lat <= 1'b0;
    else        vac_lat <= vac_cond || (vac_lat && vac_degraded);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cause_q <= CAUSE_NONE;
    else if (fast_hit && !fast_lat)  cause_q <= CAUSE_REFL;
    else if (vac_cond && !vac_lat)   cause_q <= CAUSE_VAC;
  end

  AST_REFL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_lat) |-> (cause_q == CAUSE_REFL)); // R9
  AST_REFL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_lat) |-> $past(clr)); // R2
  AST_VAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vac_lat && vac_degraded) |=> vac_lat); // R4
endmodule

// File: rtl/rf_interlock.sv
module rf_interlock #(
  parameter int AMP_W    = 12,
  parameter int CNT_W    = 8,
  parameter int PRES_W   = 16,
  parameter int DAC_W    = 14,
  parameter int DEF_TRIP = 100,
  parameter int DEF_REC  = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AMP_W-1:0]  in_amp,
  input  logic [AMP_W-1:0]  bd_thr,
  input  logic [AMP_W-1:0]  trip_thr,
  input  logic [CNT_W-1:0]  cnt_limit,
  output logic [CNT_W-1:0]  bd_count,
  input  logic [PRES_W-1:0] pressure,
  input  logic              cfg_we,
  input  logic [PRES_W-1:0] cfg_trip,
  input  logic [PRES_W-1:0] cfg_rec,
  output logic              vac_degraded,
  input  logic              clr,
  input  logic [DAC_W-1:0]  dac_in,
  output logic [DAC_W-1:0]  dac_out,
  output logic              kill,
  output logic [1:0]        trip_cause,
  output logic              cap_valid,
  input  logic              cap_ready,
  output logic [AMP_W-1:0]  cap_amp
);
  logic accept;
  logic fast_hit;
  logic vac_cond;
  logic clr_ok;

  rfi_vac_monitor #(
    .PRES_W(PRES_W), .DEF_TRIP(DEF_TRIP), .DEF_REC(DEF_REC)
  ) u_vac (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_trip(cfg_trip),
    .cfg_rec(cfg_rec), .pressure(pressure), .degraded(vac_degraded)
  );

  rfi_bd_tracker #(.AMP_W(AMP_W), .CNT_W(CNT_W)) u_bd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_amp(in_amp),
    .bd_thr(bd_thr), .cnt_clear(clr_ok), .cap_ready(cap_ready),
    .in_ready(in_ready), .accept(accept), .count(bd_count),
    .cap_valid(cap_valid), .cap_amp(cap_amp)
  );

  assign fast_hit = accept && (in_amp > trip_thr);
  assign vac_cond = vac_degraded && (bd_count > cnt_limit);

  rfi_trip_ctrl u_trip (
    .clk(clk), .rst_n(rst_n), .fast_hit(fast_hit), .vac_cond(vac_cond),
    .vac_degraded(vac_degraded), .clr(clr), .clr_ok(clr_ok),
    .kill(kill), .cause(trip_cause)
  );

  assign dac_out = kill ? '0 : dac_in;

  AST_VAC_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    (vac_degraded && (bd_count > cnt_limit)) |-> (dac_out == '0)); // R4
endmodule

// File: tb/tb_rf_interlock.sv
module tb_rf_interlock;
  localparam int AMP_W = 12, CNT_W = 4, PRES_W = 16, DAC_W = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [AMP_W-1:0] in_amp = '0, bd_thr = 12'd1000, trip_thr = 12'd3000;
  logic [CNT_W-1:0] cnt_limit = 4'd2, bd_count;
  logic [PRES_W-1:0] pressure = '0, cfg_trip = '0, cfg_rec = '0;
  logic cfg_we = 1'b0, vac_degraded, clr = 1'b0, kill;
  logic [DAC_W-1:0] dac_in = 14'h155, dac_out;
  logic [1:0] trip_cause;
  logic cap_valid, cap_ready = 1'b1;
  logic [AMP_W-1:0] cap_amp;

  int n_tests = 0, n_fail = 0;
  logic [AMP_W-1:0] exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  rf_interlock #(.AMP_W(AMP_W), .CNT_W(CNT_W), .PRES_W(PRES_W), .DAC_W(DAC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_amp(in_amp), .bd_thr(bd_thr), .trip_thr(trip_thr),
    .cnt_limit(cnt_limit), .bd_count(bd_count), .pressure(pressure),
    .cfg_we(cfg_we), .cfg_trip(cfg_trip), .cfg_rec(cfg_rec),
    .vac_degraded(vac_degraded), .clr(clr), .dac_in(dac_in),
    .dac_out(dac_out), .kill(kill), .trip_cause(trip_cause),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_amp(cap_amp)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // driver: one pulse, pushes an expected capture on a breakdown
  task automatic pulse(input logic [AMP_W-1:0] a);
    in_valid = 1'b1;
    in_amp   = a;
    if (a > bd_thr) exp_q.push_back(a);
    tick(1);
    in_valid = 1'b0;
  endtask

  // monitor: compares each capture transfer with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (cap_valid && cap_ready && rst_n) begin
        if (exp_q.size() == 0) check("R7 unexpected capture", cap_amp, -1);
        else check("R7 capture amplitude", cap_amp, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    check("R10 kill", kill, 0);
    check("R10 dac_out", dac_out, 14'h155);
    check("R10 bd_count", bd_count, 0);
    check("R10 cap_valid", cap_valid, 0);
    check("R10 in_ready", in_ready, 1);
    check("R9 cause at reset", trip_cause, 0);

    // R6/R7 breakdown detection
    pulse(12'd500);
    pulse(12'd1000);
    pulse(12'd1500);
    tick(1);
    check("R6 count after one breakdown", bd_count, 1);
    check("R1 no kill below trip", kill, 0);

    // R3/R5 hysteresis with reset levels 100/50
    pressure = 16'd100; tick(1);
    check("R3 equal to trip level", vac_degraded, 0);
    pressure = 16'd120; tick(1);
    check("R5 default trip level", vac_degraded, 1);
    pressure = 16'd80;  tick(1);
    check("R3 hold in band", vac_degraded, 1);
    pressure = 16'd50;  tick(1);
    check("R3 hold at recovery level", vac_degraded, 1);
    pressure = 16'd49;  tick(1);
    check("R3 clear below recovery", vac_degraded, 0);

    // R4 count-and-vacuum trip
    pulse(12'd1200);
    pulse(12'd1300);
    tick(1);
    check("R4 count over limit", bd_count, 3);
    check("R4 no kill with good vacuum", kill, 0);
    pressure = 16'd150; tick(1);
    check("R4 kill when degraded", kill, 1);
    check("R4 dac zero", dac_out, 0);
    tick(1);
    check("R9 cause vacuum", trip_cause, 2);
    pressure = 16'd80;
    clr = 1'b1; tick(1); clr = 1'b0;
    tick(1);
    check("R4 clr ignored", kill, 1);
    check("R2 count kept during fault", bd_count, 3);
    pressure = 16'd40; tick(1);
    check("R4 still off first edge", kill, 1);
    tick(1);
    check("R4 release after recovery", kill, 0);
    check("R4 dac restored", dac_out, 14'h155);

    clr = 1'b1; tick(1); clr = 1'b0;
    check("R6 clr zeroes count", bd_count, 0);

    // R1/R2 fast trip
    in_valid = 1'b1; in_amp = 12'd3500; exp_q.push_back(12'd3500);
    #1;
    check("R1 same-cycle kill", kill, 1);
    check("R1 same-cycle dac zero", dac_out, 0);
    tick(1); in_valid = 1'b0;
    check("R1 latched", kill, 1);
    check("R9 cause reflected", trip_cause, 1);
    pulse(12'd200);
    check("R2 stays latched without clr", kill, 1);
    clr = 1'b1; in_valid = 1'b1; in_amp = 12'd3600; exp_q.push_back(12'd3600);
    tick(1); in_valid = 1'b0; clr = 1'b0;
    tick(1);
    check("R2 clr blocked by new hit", kill, 1);
    clr = 1'b1; tick(1); clr = 1'b0;
    check("R2 clr releases", kill, 0);
    check("R9 cause holds", trip_cause, 1);

    // R5 programmed levels 300/200
    cfg_trip = 16'd300; cfg_rec = 16'd200; cfg_we = 1'b1; tick(1); cfg_we = 1'b0;
    pressure = 16'd250; tick(1);
    check("R5 below new trip", vac_degraded, 0);
    pressure = 16'd301; tick(1);
    check("R5 above new trip", vac_degraded, 1);
    pressure = 16'd210; tick(1);
    check("R5 hold above new recovery", vac_degraded, 1);
    pressure = 16'd199; tick(1);
    check("R5 clear below new recovery", vac_degraded, 0);

    // R7/R8 back-pressure
    cap_ready = 1'b0;
    pulse(12'd1500);
    check("R8 ready low while pending", in_ready, 0);
    check("R7 capture pending", cap_valid, 1);
    tick(2);
    check("R7 held", cap_valid, 1);
    check("R7 amplitude stable", cap_amp, 1500);
    cap_ready = 1'b1;
    #1;
    check("R8 ready with cap_ready", in_ready, 1);
    tick(1);
    check("R7 drained", cap_valid, 0);

    // R6 saturation
    clr = 1'b1; tick(1); clr = 1'b0;
    for (int i = 0; i < 17; i++) pulse(12'd1100);
    tick(1);
    check("R6 saturates", bd_count, 15);
    check("R4 no trip with good vacuum", kill, 0);

    tick(2);
    check("R7 all captures seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule